// File: doc/BRIEF.md
# Delta-Sigma Converter Frame Reader

This block is the host-side master for a 24-bit delta-sigma converter. The converter runs in external serial clock mode and makes one conversion per readout. When the user side requests a reading, the block pulls the active-low select line down while the serial clock is held low. It waits a settling interval and then reads the conversion-status flag that the converter drives on its data line. If the converter is still busy, the block drops the select, waits a retry gap and tries again. Once the flag shows the conversion is finished, it clocks in one 32-bit frame and releases the select. The last falling clock edge of the frame starts the next conversion in the converter.

The captured word is split into a 24-bit result and three header faults, and these are presented with a one-cycle valid pulse. An optional limit on the number of busy polls ends a request with a timeout pulse if the converter never reports completion.

Top module: `dsadc_reader`

## Requirements
- R1: After reset the select output is high (deselected), the serial clock is low, and the valid and timeout pulses are low.
- R2: The serial clock is high only while the select is low, and it is low in every cycle where the select falls.
- R3: At least SETTLE_CYCLES cycles pass between the select falling and the first rising serial clock edge that follows it.
- R4: If the status flag reads 1 (busy) when sampled, the block raises the select with no clock pulses, keeps it high for RETRY_CYCLES cycles, then selects again and repeats the settle and poll.
- R5: A readout gives exactly 32 rising serial clock edges with a period of CLK_DIV cycles, each high phase lasting CLK_DIV/2 cycles. After the 32nd falling edge the select rises.
- R6: Data is captured on rising clock edges, most significant bit first, so the first bit on the line lands in raw bit 31. The result output equals raw bits 27 down to 4, and the low 4 bits are discarded.
- R7: The dummy fault equals raw bit 30. The sign fault is set when raw bit 29 is 0. The range fault equals raw bit 28.
- R8: The valid output is a one-cycle pulse that comes while the select is high, after the frame. Raw, result and faults hold their values until the next frame completes.
- R9: A start request is acted on only when the block is idle. A request made during a readout starts no further selection.
- R10: With POLL_LIMIT nonzero, POLL_LIMIT busy polls in a row end the request. The block gives a one-cycle timeout pulse, no valid pulse, leaves the select high and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one reading; used only when idle |
| adc_cs_n_o | output | 1 | Active-low converter select |
| adc_sck_o | output | 1 | Serial clock to the converter |
| adc_sdo_i | input | 1 | Serial data and status flag from the converter |
| valid_o | output | 1 | One-cycle pulse: a new reading is on the outputs |
| result_o | output | 24 | Conversion result, raw bits 27..4 |
| raw_o | output | 32 | Full captured frame |
| fault_dummy_o | output | 1 | Dummy bit was 1 |
| fault_sign_o | output | 1 | Sign bit was 0 (non-positive input) |
| fault_range_o | output | 1 | Extended-range bit was 1 |
| timeout_o | output | 1 | One-cycle pulse: poll limit reached |

## Verification
The hardest situation to reach from the ports is a converter that stays busy for a chosen number of polls, because busy is a property of the converter and not of the block. The bench's converter model numbers each selection and reports busy until the selection count passes a limit that the test sets. This lets each vector ask for zero, one or two retries, and a directed test ask for more busy polls than POLL_LIMIT, which drives the timeout path. Bit alignment is covered by a model that moves to the next frame bit on every falling serial clock edge, with words whose header and low nibbles differ.

// File: rtl/dsadc_pkg.sv
// Package: shared frame layout and controller state encoding for the
// delta-sigma frame reader. Bit positions here are fixed by the converter.
package dsadc_pkg;

    localparam int FRAME_BITS  = 32;
    localparam int RESULT_BITS = 24;
    localparam int SUB_BITS    = 4;
    localparam int POS_STATUS  = 31;
    localparam int POS_DUMMY   = 30;
    localparam int POS_SIGN    = 29;
    localparam int POS_RANGE   = 28;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT_WAIT,
        ST_POLL,
        ST_RETRY_GAP,
        ST_SHIFT,
        ST_DONE
    } rd_state_t;

    typedef struct packed {
        logic dummy;
        logic sign;
        logic range;
    } hdr_fault_t;

endpackage

// File: rtl/dsadc_sck_gen.sv
// Serial clock generator. When enabled, it produces a clock with period
// CLK_DIV system cycles that starts low, and it flags the cycle in which
// the clock goes high (capture point) and the cycle in which it goes low.
// Assumes CLK_DIV is even and at least 2. When disabled, the clock is low
// and the phase counter is cleared.
module dsadc_sck_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sck_o,
    output logic rise_tick_o,
    output logic fall_tick_o
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);
    localparam logic [CW-1:0] LAST    = CW'(CLK_DIV - 1);

    generate
        if ((CLK_DIV < 2) || ((CLK_DIV % 2) != 0)) begin : g_bad_div
            $error("CLK_DIV must be even and at least 2");
        end
    endgenerate

    logic [CW-1:0] phase_q;
    logic          sck_q;

    assign rise_tick_o = en_i && (phase_q == RISE_AT);
    assign fall_tick_o = en_i && (phase_q == LAST);
    assign sck_o       = sck_q;

    // Advance the phase counter and set the clock level at the half points.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            phase_q <= '0;
            sck_q   <= 1'b0;
        end else begin
            if (fall_tick_o) begin
                phase_q <= '0;
                sck_q   <= 1'b0;
            end else begin
                phase_q <= phase_q + 1'b1;
                if (rise_tick_o) begin
                    sck_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dsadc_frame_shift.sv
// Frame shifter. Shifts the data line in, most significant bit first, on
// each capture tick. It counts falling clock ticks and flags the last one
// of a frame. Assumes the capture ticks and falling ticks alternate.
// clear_i resets the edge count between frames.
module dsadc_frame_shift #(
    parameter int NBITS = dsadc_pkg::FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             capture_i,
    input  logic             fall_i,
    input  logic             sdo_i,
    output logic [NBITS-1:0] word_o,
    output logic             last_fall_o
);
    localparam int BW = $clog2(NBITS);
    localparam logic [BW-1:0] LAST_EDGE = BW'(NBITS - 1);

    logic [NBITS-1:0] shreg_q;
    logic [BW-1:0]    edges_q;

    assign word_o      = shreg_q;
    assign last_fall_o = fall_i && (edges_q == LAST_EDGE);

    // Capture one data bit per rising clock edge, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (capture_i) begin
            shreg_q <= {shreg_q[NBITS-2:0], sdo_i};
        end
    end

    // Count completed clock cycles within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            edges_q <= '0;
        end else if (fall_i) begin
            edges_q <= edges_q + 1'b1;
        end
    end

endmodule

// File: rtl/dsadc_frame_decode.sv
// Frame decoder. On load it registers the raw frame, the 24-bit result
// (sub-LSB nibble dropped) and the three header faults, and it pulses
// valid for one cycle. Outputs hold until the next load.
module dsadc_frame_decode
    import dsadc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [FRAME_BITS-1:0]  word_i,
    output logic [FRAME_BITS-1:0]  raw_o,
    output logic [RESULT_BITS-1:0] result_o,
    output hdr_fault_t             faults_o,
    output logic                   valid_o
);
    hdr_fault_t hdr_now;

    // Decode the header bits of the incoming word.
    always_comb begin
        hdr_now.dummy = word_i[POS_DUMMY];
        hdr_now.sign  = ~word_i[POS_SIGN];
        hdr_now.range = word_i[POS_RANGE];
    end

    // Register the decoded reading and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_o    <= '0;
            result_o <= '0;
            faults_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                raw_o    <= word_i;
                result_o <= word_i[SUB_BITS +: RESULT_BITS];
                faults_o <= hdr_now;
            end
        end
    end

endmodule

// File: rtl/dsadc_reader.sv
// Delta-sigma converter frame reader (top). It selects the converter with
// the clock held low, waits SETTLE_CYCLES, and polls the status flag. While
// the converter is busy it deselects for RETRY_CYCLES and polls again, up
// to POLL_LIMIT busy polls (0 = no limit). When the flag shows done, it
// clocks in one 32-bit frame and reports it. Assumes adc_sdo_i is
// synchronous to clk; the converter changes it only after falling serial
// clock edges, which this block generates from clk.
module dsadc_reader
    import dsadc_pkg::*;
#(
    parameter int CLK_DIV       = 8,
    parameter int SETTLE_CYCLES = 5000,
    parameter int RETRY_CYCLES  = 500,
    parameter int POLL_LIMIT    = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    output logic                   adc_cs_n_o,
    output logic                   adc_sck_o,
    input  logic                   adc_sdo_i,
    output logic                   valid_o,
    output logic [RESULT_BITS-1:0] result_o,
    output logic [FRAME_BITS-1:0]  raw_o,
    output logic                   fault_dummy_o,
    output logic                   fault_sign_o,
    output logic                   fault_range_o,
    output logic                   timeout_o
);
    localparam int WAIT_MAX = (SETTLE_CYCLES > RETRY_CYCLES) ? SETTLE_CYCLES : RETRY_CYCLES;
    localparam int WW       = $clog2(WAIT_MAX + 1);
    localparam int PW       = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;
    localparam logic [WW-1:0] SETTLE_LAST = WW'(SETTLE_CYCLES - 1);
    localparam logic [WW-1:0] RETRY_LAST  = WW'(RETRY_CYCLES - 1);

    generate
        if ((SETTLE_CYCLES < 1) || (RETRY_CYCLES < 1)) begin : g_bad_wait
            $error("SETTLE_CYCLES and RETRY_CYCLES must be at least 1");
        end
    endgenerate

    rd_state_t             state_q, state_nxt;
    logic [WW-1:0]         wait_q;
    logic [PW-1:0]         poll_q;
    logic                  limit_hit;
    logic                  cs_n_q;
    logic                  timeout_q;
    logic                  sck_en;
    logic                  rise_tick, fall_tick;
    logic                  last_fall;
    logic [FRAME_BITS-1:0] frame_word;
    hdr_fault_t            faults;

    // Poll limit variant: compare against the limit, or never time out.
    generate
        if (POLL_LIMIT == 0) begin : g_no_limit
            assign limit_hit = 1'b0;
        end else begin : g_limit
            assign limit_hit = (poll_q == PW'(POLL_LIMIT - 1));
        end
    endgenerate

    // Next-state logic of the readout sequence.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i) state_nxt = ST_SELECT_WAIT;
            ST_SELECT_WAIT: if (wait_q == SETTLE_LAST) state_nxt = ST_POLL;
            ST_POLL: begin
                if (!adc_sdo_i)     state_nxt = ST_SHIFT;
                else if (limit_hit) state_nxt = ST_IDLE;
                else                state_nxt = ST_RETRY_GAP;
            end
            ST_RETRY_GAP:   if (wait_q == RETRY_LAST) state_nxt = ST_SELECT_WAIT;
            ST_SHIFT:       if (last_fall) state_nxt = ST_DONE;
            ST_DONE:        state_nxt = ST_IDLE;
            default:        state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Settle and retry-gap timer: cleared on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || (state_nxt != state_q)) begin
            wait_q <= '0;
        end else if ((state_q == ST_SELECT_WAIT) || (state_q == ST_RETRY_GAP)) begin
            wait_q <= wait_q + 1'b1;
        end
    end

    // Busy-poll counter for the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_q <= '0;
        end else if ((state_q == ST_IDLE) && start_i) begin
            poll_q <= '0;
        end else if ((state_q == ST_POLL) && adc_sdo_i) begin
            poll_q <= poll_q + 1'b1;
        end
    end

    // Registered select, low in the states where the converter is addressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
        end else begin
            cs_n_q <= !((state_nxt == ST_SELECT_WAIT) || (state_nxt == ST_POLL) ||
                        (state_nxt == ST_SHIFT));
        end
    end

    // Timeout pulse when the last allowed poll still reads busy.
    always_ff @(posedge clk) begin
        if (!rst_n) timeout_q <= 1'b0;
        else        timeout_q <= (state_q == ST_POLL) && adc_sdo_i && limit_hit;
    end

    assign sck_en = (state_q == ST_SHIFT);

    dsadc_sck_gen #(
        .CLK_DIV(CLK_DIV)
    ) u_sck (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (sck_en),
        .sck_o      (adc_sck_o),
        .rise_tick_o(rise_tick),
        .fall_tick_o(fall_tick)
    );

    dsadc_frame_shift #(
        .NBITS(FRAME_BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (!sck_en),
        .capture_i  (rise_tick),
        .fall_i     (fall_tick),
        .sdo_i      (adc_sdo_i),
        .word_o     (frame_word),
        .last_fall_o(last_fall)
    );

    dsadc_frame_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (state_q == ST_DONE),
        .word_i  (frame_word),
        .raw_o   (raw_o),
        .result_o(result_o),
        .faults_o(faults),
        .valid_o (valid_o)
    );

    assign adc_cs_n_o    = cs_n_q;
    assign timeout_o     = timeout_q;
    assign fault_dummy_o = faults.dummy;
    assign fault_sign_o  = faults.sign;
    assign fault_range_o = faults.range;

endmodule

// File: rtl/dsadc_reader_chk.sv
// Protocol checker for dsadc_reader, attached by bind. It watches only the
// converter-side pins and the result pulses, and it keeps its own counters
// for the settle window and the clock edges in each selection.
module dsadc_reader_chk #(
    parameter int SETTLE_CYCLES = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic valid,
    input logic timeout
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] SETTLE_SAT = SW'(SETTLE_CYCLES);

    logic [SW-1:0] sel_cnt;
    logic [6:0]    rise_cnt;
    logic          sck_d;

    // Count cycles since select fell, saturating at the settle length.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n)          sel_cnt <= '0;
        else if (sel_cnt != SETTLE_SAT) sel_cnt <= sel_cnt + 1'b1;
    end

    // Count rising clock edges within one selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sck_d <= sck;
            if (cs_n)              rise_cnt <= '0;
            else if (sck && !sck_d) rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r2_sck_low_at_select: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sck);
    a_r2_sck_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
    a_r3_settle_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> (sel_cnt >= SETTLE_SAT));
    a_r5_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ((rise_cnt == 7'd0) || (rise_cnt == 7'd32)));
    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r8_valid_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> cs_n);
    a_r10_timeout_excl: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!valid && cs_n));

endmodule

bind dsadc_reader dsadc_reader_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (adc_cs_n_o),
    .sck    (adc_sck_o),
    .valid  (valid_o),
    .timeout(timeout_o)
);

// File: tb/sim_dsadc_reader.sv
module sim_dsadc_reader;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int DIV        = 4;
    localparam int SETTLE     = 6;
    localparam int RETRY      = 5;
    localparam int LIMIT      = 3;

    typedef struct packed {
        logic [31:0] word;
        logic [1:0]  busy;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{32'h2ABC_DEF5, 2'd0},
        '{32'h2000_0000, 2'd1},
        '{32'h2FFF_FFFF, 2'd2},
        '{32'h5123_4560, 2'd0},
        '{32'h1800_0001, 2'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cs_n, sck, sdo, valid, timeout;
    logic        f_dummy, f_sign, f_range;
    logic [23:0] result;
    logic [31:0] raw;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dsadc_reader #(
        .CLK_DIV(DIV), .SETTLE_CYCLES(SETTLE), .RETRY_CYCLES(RETRY), .POLL_LIMIT(LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .adc_cs_n_o(cs_n), .adc_sck_o(sck), .adc_sdo_i(sdo),
        .valid_o(valid), .result_o(result), .raw_o(raw),
        .fault_dummy_o(f_dummy), .fault_sign_o(f_sign), .fault_range_o(f_range),
        .timeout_o(timeout)
    );

    // Converter model: busy for selections numbered below busy_until.
    logic [31:0] model_word = 32'h0;
    int          busy_until = 0;
    int          sel_no = 0;
    logic        conv_busy = 1'b0;
    int          base_fall = 0;
    int          fall_total = 0;
    int          cur_bit;

    always @(negedge cs_n) begin
        conv_busy = (sel_no < busy_until);
        sel_no    = sel_no + 1;
        base_fall = fall_total;
    end
    always @(negedge sck) fall_total = fall_total + 1;

    assign cur_bit = fall_total - base_fall;
    assign sdo = cs_n ? 1'b0 :
                 (cur_bit == 0) ? (conv_busy ? 1'b1 : model_word[31]) :
                 (cur_bit < 32) ? model_word[31 - cur_bit] : 1'b0;

    // Pin monitor, sampled on the falling system clock edge.
    int clr_req = 0, clr_ack = 0;
    int t = 0, last_rise = 0, t_csfall = 0, t_csrise = 0;
    int rises_sel = 0, frame_rises = 0, retries = 0, cs_falls = 0;
    int period_bad = 0, settle_bad = 0, r2_bad = 0, gap_bad = 0;
    int valid_cnt = 0, timeout_cnt = 0, cur_vlen = 0, max_vlen = 0;
    logic prev_cs = 1'b1, prev_sck = 1'b0, last_was_retry = 1'b0;

    always @(negedge clk) begin
        if (clr_req != clr_ack) begin
            frame_rises = 0; retries = 0; cs_falls = 0;
            period_bad = 0; settle_bad = 0; r2_bad = 0; gap_bad = 0;
            valid_cnt = 0; timeout_cnt = 0; max_vlen = 0;
            clr_ack = clr_req;
        end
        t = t + 1;
        if (sck && cs_n) r2_bad = r2_bad + 1;
        if (!cs_n && prev_cs) begin
            cs_falls = cs_falls + 1;
            if (sck) r2_bad = r2_bad + 1;
            if (last_was_retry && (t - t_csrise < RETRY)) gap_bad = gap_bad + 1;
            t_csfall = t;
            rises_sel = 0;
        end
        if (sck && !prev_sck) begin
            if (rises_sel == 0) begin
                if (t - t_csfall < SETTLE) settle_bad = settle_bad + 1;
            end else if (t - last_rise != DIV) begin
                period_bad = period_bad + 1;
            end
            rises_sel = rises_sel + 1;
            last_rise = t;
        end
        if (!sck && prev_sck && (t - last_rise != DIV / 2)) period_bad = period_bad + 1;
        if (cs_n && !prev_cs) begin
            t_csrise = t;
            if (rises_sel == 0) begin
                retries = retries + 1;
                last_was_retry = 1'b1;
            end else begin
                frame_rises = rises_sel;
                last_was_retry = 1'b0;
            end
        end
        if (valid) begin
            valid_cnt = valid_cnt + 1;
            cur_vlen = cur_vlen + 1;
        end else begin
            cur_vlen = 0;
        end
        if (cur_vlen > max_vlen) max_vlen = cur_vlen;
        if (timeout) timeout_cnt = timeout_cnt + 1;
        prev_cs  = cs_n;
        prev_sck = sck;
    end

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #(Q);
        end
    endtask

    task automatic clear_stats();
        clr_req = clr_req + 1;
        tick(1);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit; i++) begin
            if ((valid_cnt > 0) || (timeout_cnt > 0)) break;
            tick(1);
        end
    endtask

    task automatic run_vector(input vec_t v);
        logic [31:0] w;
        w = v.word;
        model_word = w;
        busy_until = sel_no + int'(v.busy);
        clear_stats();
        pulse_start();
        wait_end(2000);
        tick(3);
        chk(valid_cnt == 1, "R8 valid count", valid_cnt, 1);
        chk(max_vlen == 1, "R8 valid width", max_vlen, 1);
        chk(raw == w, "R6 raw frame", raw, w);
        chk(result == w[27:4], "R6 result", {8'h0, result}, {8'h0, w[27:4]});
        chk({f_dummy, f_sign, f_range} == {w[30], ~w[29], w[28]}, "R7 faults",
            {f_dummy, f_sign, f_range}, {w[30], ~w[29], w[28]});
        chk(frame_rises == 32, "R5 edge count", frame_rises, 32);
        chk(period_bad == 0, "R5 clock timing", period_bad, 0);
        chk(settle_bad == 0, "R3 settle", settle_bad, 0);
        chk(r2_bad == 0, "R2 clock low at select", r2_bad, 0);
        chk(retries == int'(v.busy), "R4 retry count", retries, v.busy);
        chk(gap_bad == 0, "R4 retry gap", gap_bad, 0);
        tick(6);
        chk(raw == w, "R8 hold", raw, w);
    endtask

    initial begin : main
        logic [31:0] w;
        tick(4);
        chk(cs_n == 1'b1, "R1 cs idle", cs_n, 1);
        chk(sck == 1'b0, "R1 sck idle", sck, 0);
        chk({valid, timeout} == 2'b00, "R1 pulses idle", {valid, timeout}, 0);
        rst_n = 1'b1;
        tick(2);

        for (int k = 0; k < NVEC; k++) run_vector(VECS[k]);

        // R9: start during a readout is ignored.
        w = 32'h2135_79BD;
        model_word = w;
        busy_until = sel_no;
        clear_stats();
        pulse_start();
        for (int i = 0; i < 200; i++) begin
            if (rises_sel >= 5) break;
            tick(1);
        end
        pulse_start();
        wait_end(2000);
        tick(40);
        chk(cs_falls == 1, "R9 no extra selection", cs_falls, 1);
        chk(cs_n == 1'b1, "R9 deselected", cs_n, 1);
        chk(raw == w, "R9 frame intact", raw, w);

        // R10: converter stays busy beyond the poll limit.
        busy_until = sel_no + 10;
        clear_stats();
        pulse_start();
        wait_end(2000);
        tick(3);
        chk(timeout_cnt == 1, "R10 timeout pulse", timeout_cnt, 1);
        chk(valid_cnt == 0, "R10 no valid", valid_cnt, 0);
        chk(cs_falls == LIMIT, "R10 poll count", cs_falls, LIMIT);
        chk(cs_n == 1'b1, "R10 deselected", cs_n, 1);
        tick(30);
        chk(cs_falls == LIMIT, "R10 stays idle", cs_falls, LIMIT);
        run_vector('{32'h2468_ACE0, 2'd0});

        // R1: reset in the middle of a frame returns the pins to idle.
        busy_until = sel_no;
        clear_stats();
        pulse_start();
        for (int i = 0; i < 200; i++) begin
            if (rises_sel >= 3) break;
            tick(1);
        end
        rst_n = 1'b0;
        tick(2);
        chk(cs_n == 1'b1, "R1 cs after reset", cs_n, 1);
        chk(sck == 1'b0, "R1 sck after reset", sck, 0);
        chk(valid == 1'b0, "R1 valid after reset", valid, 0);
        rst_n = 1'b1;
        tick(2);
        run_vector('{32'h2FED_CBA9, 2'd1});

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule